// File: doc/BRIEF.md
# Serial Configuration Loader

This block loads a bitstream into a downstream programmable device through its passive serial configuration port. When software or a controller pulses `start`, the loader pulls the active-low configuration request low for a fixed hold time, then releases it. With a target present, it then waits for the target's active-low status line to read high. That wait is bounded by a programmable cycle limit.

Once the target is ready, the loader takes exactly `byte_count` bytes from a valid/ready byte stream. It shifts each byte out on a single data line, lowest bit first, under a divided data clock. The next byte is taken only after the current byte is fully shifted out.

After a load, a completion check request samples the synchronised status and done inputs and returns a three-way result: success, failure or still programming. A build-time switch supports boards with no target fitted. In that case the status wait is skipped and every check reports success.

Top module: `serial_cfg_loader`

## Requirements
- R1: After `start` is accepted in idle, `cfg_n_o` is low for exactly HOLD_US * (CLK_HZ / 1e6) clock cycles and then returns high; out of reset it is high.
- R2: With a target present, no rising edge of `dclk_o` occurs before the target's status input has read high after the request was released.
- R3: Exactly `byte_count` bytes are accepted and shifted, in arrival order, each lowest bit first; a target capturing `data_o` on rising `dclk_o` edges rebuilds the original bytes.
- R4: Each bit is placed on `data_o` while `dclk_o` is low and held stable while `dclk_o` is high; every high phase lasts DCLK_DIV cycles, and each byte gives eight rising edges.
- R5: `s_ready` is low out of reset, outside the streaming phase and while a byte is being shifted; a new byte is taken only after the eighth falling edge of the previous one.
- R6: If the status input does not read high within `timeout_cycles` cycles of the request release, `timeout_err` goes high and stays high until the next `start`, `busy` returns low and no data clock is produced.
- R7: A completion check (`check` pulsed while idle) with the status input low gives `result_valid` one cycle later with `result` = 2'b10 (failure).
- R8: A check with status high gives `result` = 2'b01 (success) when done is high and 2'b11 (in progress) when done is low.
- R9: With HAS_TARGET = 0, the status wait is skipped, the load completes with the status input held low, and every check gives `result` = 2'b01.
- R10: A load with `byte_count` = 0 returns to idle after the status handshake without any data-clock edge and without raising `s_ready`.
- R11: The status and done inputs pass through two flops before use; a change of `done_i` made in the same cycle as a check request does not affect that check's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load sequence (honoured in idle) |
| byte_count | input | CNT_W | Number of bytes for this load, latched at start |
| timeout_cycles | input | TO_W | Status wait limit in cycles, latched at start |
| s_valid | input | 1 | Byte stream valid |
| s_data | input | 8 | Byte stream data |
| s_ready | output | 1 | Loader can take a byte this cycle |
| check | input | 1 | Request a completion check (honoured in idle) |
| cfg_n_o | output | 1 | Active-low configuration request to the target |
| dclk_o | output | 1 | Configuration data clock |
| data_o | output | 1 | Configuration serial data |
| stat_n_i | input | 1 | Target status, active low, asynchronous |
| done_i | input | 1 | Target configuration done, asynchronous |
| busy | output | 1 | A load sequence is in progress |
| xfer_done | output | 1 | One-cycle pulse when all bytes are shifted |
| timeout_err | output | 1 | Status wait timed out (sticky until next start) |
| result_valid | output | 1 | One-cycle pulse carrying a check result |
| result | output | 2 | 01 success, 10 failure, 11 in progress |

## Verification
Loads run with random byte values and random lengths from one to five bytes. Random gaps between stream bytes show whether flow control holds when the host stalls. Random target status delays show whether any data clock slips out ahead of the handshake. A target that never answers separates the timeout path from a hang, and a zero-length load separates the empty case from an off-by-one byte count. Checks made with status low, with done low, with done high, and with done raised in the same cycle as the request tell the three results apart and expose a missing synchroniser stage. A second instance built without a target confirms that the wait is skipped.

// File: rtl/scl_pkg.sv
package scl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PULSE  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_STREAM = 2'd3
    } seq_st_e;

    typedef enum logic [1:0] {
        RES_NONE    = 2'b00,
        RES_OK      = 2'b01,
        RES_FAIL    = 2'b10,
        RES_PENDING = 2'b11
    } load_res_e;

endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stage_d[s] = async_i;
            end else begin : g_next
                always_comb stage_d[s] = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/scl_shifter.sv
module scl_shifter #(
    parameter int DCLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] byte_i,
    output logic       dclk_o,
    output logic       data_o,
    output logic       busy_o,
    output logic       fin_o
);
    localparam int DW = (DCLK_DIV < 2) ? 1 : $clog2(DCLK_DIV);

    typedef struct packed {
        logic [7:0]    sh;
        logic [2:0]    bitn;
        logic [DW-1:0] div;
        logic          dclk;
        logic          busy;
        logic          fin;
    } sh_s;

    sh_s sh_d, sh_q;

    always_comb begin
        sh_d     = sh_q;
        sh_d.fin = 1'b0;
        if (load_i && !sh_q.busy) begin
            sh_d.sh   = byte_i;
            sh_d.bitn = '0;
            sh_d.div  = '0;
            sh_d.dclk = 1'b0;
            sh_d.busy = 1'b1;
        end else if (sh_q.busy) begin
            if (sh_q.div == DW'(DCLK_DIV - 1)) begin
                sh_d.div = '0;
                if (!sh_q.dclk) begin
                    sh_d.dclk = 1'b1;
                end else begin
                    sh_d.dclk = 1'b0;
                    if (sh_q.bitn == 3'd7) begin
                        sh_d.busy = 1'b0;
                        sh_d.fin  = 1'b1;
                    end else begin
                        sh_d.bitn = sh_q.bitn + 3'd1;
                        sh_d.sh   = {1'b0, sh_q.sh[7:1]};
                    end
                end
            end else begin
                sh_d.div = sh_q.div + DW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dclk_o = sh_q.dclk;
    assign data_o = sh_q.sh[0];
    assign busy_o = sh_q.busy;
    assign fin_o  = sh_q.fin;
endmodule

// File: rtl/scl_seq.sv
module scl_seq
    import scl_pkg::*;
#(
    parameter int HOLD_CYC   = 40,
    parameter int CNT_W      = 16,
    parameter int TO_W       = 20,
    parameter bit HAS_TARGET = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] byte_count_i,
    input  logic [TO_W-1:0]  timeout_i,
    input  logic             stat_ok_i,
    input  logic             done_i,
    input  logic             check_i,
    input  logic             s_valid_i,
    input  logic             sh_busy_i,
    output logic             s_ready_o,
    output logic             load_o,
    output logic             cfg_n_o,
    output logic             busy_o,
    output logic             xfer_done_o,
    output logic             timeout_err_o,
    output logic             result_valid_o,
    output logic [1:0]       result_o
);
    localparam int HW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);

    typedef struct packed {
        seq_st_e          st;
        logic [HW-1:0]    hcnt;
        logic [TO_W-1:0]  wcnt;
        logic [TO_W-1:0]  tlim;
        logic [CNT_W-1:0] rem;
        logic             cfg_n;
        logic             busy;
        logic             err;
        logic             xdone;
        logic             rvalid;
        load_res_e        res;
    } seq_s;

    seq_s seq_d, seq_q;
    logic ready_c;
    logic take_c;

    always_comb begin
        ready_c = (seq_q.st == ST_STREAM) && !sh_busy_i && (seq_q.rem != '0);
        take_c  = ready_c && s_valid_i;
    end

    always_comb begin
        seq_d        = seq_q;
        seq_d.xdone  = 1'b0;
        seq_d.rvalid = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.st    = ST_PULSE;
                    seq_d.hcnt  = '0;
                    seq_d.wcnt  = '0;
                    seq_d.tlim  = timeout_i;
                    seq_d.rem   = byte_count_i;
                    seq_d.cfg_n = 1'b0;
                    seq_d.busy  = 1'b1;
                    seq_d.err   = 1'b0;
                end else if (check_i) begin
                    seq_d.rvalid = 1'b1;
                    if (!HAS_TARGET)     seq_d.res = RES_OK;
                    else if (!stat_ok_i) seq_d.res = RES_FAIL;
                    else if (done_i)     seq_d.res = RES_OK;
                    else                 seq_d.res = RES_PENDING;
                end
            end
            ST_PULSE: begin
                if (seq_q.hcnt == HW'(HOLD_CYC - 1)) begin
                    seq_d.cfg_n = 1'b1;
                    seq_d.st    = HAS_TARGET ? ST_WAIT : ST_STREAM;
                end else begin
                    seq_d.hcnt = seq_q.hcnt + HW'(1);
                end
            end
            ST_WAIT: begin
                if (stat_ok_i) begin
                    seq_d.st = ST_STREAM;
                end else if (seq_q.wcnt == seq_q.tlim) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.err  = 1'b1;
                    seq_d.busy = 1'b0;
                end else begin
                    seq_d.wcnt = seq_q.wcnt + TO_W'(1);
                end
            end
            ST_STREAM: begin
                if (take_c) begin
                    seq_d.rem = seq_q.rem - CNT_W'(1);
                end else if (seq_q.rem == '0 && !sh_busy_i) begin
                    seq_d.st    = ST_IDLE;
                    seq_d.busy  = 1'b0;
                    seq_d.xdone = 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.st    <= ST_IDLE;
            seq_q.cfg_n <= 1'b1;
            seq_q.res   <= RES_NONE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign s_ready_o      = ready_c;
    assign load_o         = take_c;
    assign cfg_n_o        = seq_q.cfg_n;
    assign busy_o         = seq_q.busy;
    assign xfer_done_o    = seq_q.xdone;
    assign timeout_err_o  = seq_q.err;
    assign result_valid_o = seq_q.rvalid;
    assign result_o       = seq_q.res;
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
    parameter int CLK_HZ     = 50_000_000,
    parameter int HOLD_US    = 40,
    parameter int DCLK_DIV   = 2,
    parameter int CNT_W      = 16,
    parameter int TO_W       = 20,
    parameter bit HAS_TARGET = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_count,
    input  logic [TO_W-1:0]  timeout_cycles,
    input  logic             s_valid,
    input  logic [7:0]       s_data,
    output logic             s_ready,
    input  logic             check,
    output logic             cfg_n_o,
    output logic             dclk_o,
    output logic             data_o,
    input  logic             stat_n_i,
    input  logic             done_i,
    output logic             busy,
    output logic             xfer_done,
    output logic             timeout_err,
    output logic             result_valid,
    output logic [1:0]       result
);
    localparam int HOLD_CYC = (CLK_HZ / 1_000_000) * HOLD_US;

    logic [1:0] sync_w;
    logic       load_w;
    logic       sh_busy_w;
    logic       sh_fin_w;

    scl_sync #(.W(2), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({done_i, stat_n_i}),
        .sync_o  (sync_w)
    );

    scl_seq #(
        .HOLD_CYC   (HOLD_CYC),
        .CNT_W      (CNT_W),
        .TO_W       (TO_W),
        .HAS_TARGET (HAS_TARGET)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .byte_count_i   (byte_count),
        .timeout_i      (timeout_cycles),
        .stat_ok_i      (sync_w[0]),
        .done_i         (sync_w[1]),
        .check_i        (check),
        .s_valid_i      (s_valid),
        .sh_busy_i      (sh_busy_w | sh_fin_w),
        .s_ready_o      (s_ready),
        .load_o         (load_w),
        .cfg_n_o        (cfg_n_o),
        .busy_o         (busy),
        .xfer_done_o    (xfer_done),
        .timeout_err_o  (timeout_err),
        .result_valid_o (result_valid),
        .result_o       (result)
    );

    scl_shifter #(.DCLK_DIV(DCLK_DIV)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_w),
        .byte_i (s_data),
        .dclk_o (dclk_o),
        .data_o (data_o),
        .busy_o (sh_busy_w),
        .fin_o  (sh_fin_w)
    );
endmodule

// File: rtl/scl_checker.sv
module scl_checker #(
    parameter int HOLD_CYC = 40
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_n_o,
    input logic       dclk_o,
    input logic       data_o,
    input logic       s_ready,
    input logic       busy,
    input logic       timeout_err,
    input logic       result_valid,
    input logic [1:0] result
);
    logic [31:0] low_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        low_run_q <= '0;
        else if (!cfg_n_o) low_run_q <= low_run_q + 32'd1;
        else               low_run_q <= '0;
    end

    p_hold_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_n_o) |-> (low_run_q == 32'(HOLD_CYC)));

    p_no_clk_in_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dclk_o) |-> cfg_n_o);

    p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dclk_o && $past(dclk_o)) |-> $stable(data_o));

    p_ready_low_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (!dclk_o && busy));

    p_timeout_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> !busy);

    p_result_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (result != 2'b00));

    p_result_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);
endmodule

bind serial_cfg_loader scl_checker #(.HOLD_CYC(HOLD_CYC)) u_scl_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_n_o      (cfg_n_o),
    .dclk_o       (dclk_o),
    .data_o       (data_o),
    .s_ready      (s_ready),
    .busy         (busy),
    .timeout_err  (timeout_err),
    .result_valid (result_valid),
    .result       (result)
);

// File: tb/serial_cfg_loader_test.sv
`timescale 1ns/1ps
module serial_cfg_loader_test;
    localparam int CNT_W = 16;
    localparam int TO_W  = 20;
    localparam int HOLD  = 40;
    localparam int DIV   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic             start = 0, s_valid = 0, check = 0, done_i = 0;
    logic [CNT_W-1:0] byte_count = '0;
    logic [TO_W-1:0]  timeout_cycles = '0;
    logic [7:0]       s_data = '0;
    logic             s_ready, cfg_n_o, dclk_o, data_o, busy, xfer_done, timeout_err, result_valid;
    logic [1:0]       result;
    logic             stat_n_r = 1'b0;

    serial_cfg_loader #(.CLK_HZ(1_000_000), .HOLD_US(40), .DCLK_DIV(DIV),
                        .CNT_W(CNT_W), .TO_W(TO_W), .HAS_TARGET(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
        .timeout_cycles(timeout_cycles), .s_valid(s_valid), .s_data(s_data),
        .s_ready(s_ready), .check(check), .cfg_n_o(cfg_n_o), .dclk_o(dclk_o),
        .data_o(data_o), .stat_n_i(stat_n_r), .done_i(done_i), .busy(busy),
        .xfer_done(xfer_done), .timeout_err(timeout_err),
        .result_valid(result_valid), .result(result));

    logic             nt_start = 0, nt_valid = 0, nt_check = 0;
    logic [7:0]       nt_data = '0;
    logic             nt_ready, nt_cfg_n, nt_dclk, nt_dat, nt_busy, nt_xd, nt_err, nt_rv;
    logic [1:0]       nt_res;

    serial_cfg_loader #(.CLK_HZ(1_000_000), .HOLD_US(40), .DCLK_DIV(DIV),
                        .CNT_W(CNT_W), .TO_W(TO_W), .HAS_TARGET(1'b0)) uut_nt (
        .clk(clk), .rst_n(rst_n), .start(nt_start), .byte_count(16'd3),
        .timeout_cycles(20'd5), .s_valid(nt_valid), .s_data(nt_data),
        .s_ready(nt_ready), .check(nt_check), .cfg_n_o(nt_cfg_n), .dclk_o(nt_dclk),
        .data_o(nt_dat), .stat_n_i(1'b0), .done_i(1'b0), .busy(nt_busy),
        .xfer_done(nt_xd), .timeout_err(nt_err),
        .result_valid(nt_rv), .result(nt_res));

    int total = 0, bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // target model: status goes high a programmable delay after request release
    int  stat_dly = 5;
    bit  tgt_fail = 0;
    int  dly_cnt = 0;
    always @(posedge clk) begin
        if (!cfg_n_o) begin
            stat_n_r <= 1'b0;
            dly_cnt  <= 0;
        end else if (tgt_fail) begin
            stat_n_r <= 1'b0;
        end else if (dly_cnt < stat_dly) begin
            dly_cnt <= dly_cnt + 1;
        end else begin
            stat_n_r <= 1'b1;
        end
    end

    // target capture on rising data clock
    logic [7:0] rx [$];
    logic [7:0] cap = '0;
    int rises = 0, bitc = 0, early = 0, nt_rises = 0;
    always @(posedge dclk_o) begin
        rises++;
        if (!stat_n_r) early++;
        cap = {data_o, cap[7:1]};
        bitc++;
        if (bitc == 8) begin
            rx.push_back(cap);
            bitc = 0;
        end
    end
    always @(posedge nt_dclk) nt_rises++;

    // port monitors
    int lo_run = 0, lo_last = 0, hi_run = 0, hi_bad = 0, ready_bad = 0, ready_seen = 0;
    logic prev_dclk = 0, prev_data = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cfg_n_o) lo_run++;
            else if (lo_run != 0) begin lo_last = lo_run; lo_run = 0; end
            if (dclk_o) begin
                hi_run++;
                if (prev_dclk && data_o !== prev_data) hi_bad++;
            end else if (hi_run != 0) begin
                if (hi_run != DIV) hi_bad++;
                hi_run = 0;
            end
            if (s_ready && dclk_o) ready_bad++;
            if (s_ready) ready_seen++;
        end
        prev_dclk = dclk_o;
        prev_data = data_o;
    end

    task automatic send_byte(input logic [7:0] b);
        s_valid = 1;
        s_data  = b;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        s_valid = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic run_load(input int n, input int dly, input int maxgap);
        int base_rx, base_r, base_early;
        logic [7:0] exp_b [$];
        stat_dly = dly;
        byte_count = CNT_W'(n);
        timeout_cycles = 20'd400;
        base_rx = rx.size();
        base_r = rises;
        base_early = early;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            exp_b.push_back(b);
            repeat ($urandom % (maxgap + 1)) @(negedge clk);
            send_byte(b);
        end
        wait_idle();
        chk(lo_last == HOLD, "R1 hold length", lo_last, HOLD);
        chk(early == base_early, "R2 clock before status", early - base_early, 0);
        chk(rx.size() - base_rx == n, "R3 byte count", rx.size() - base_rx, n);
        for (int i = 0; i < n; i++)
            if (base_rx + i < rx.size())
                chk(rx[base_rx + i] == exp_b[i], "R3 byte value", rx[base_rx + i], exp_b[i]);
        chk(rises - base_r == 8 * n, "R4 rising edges", rises - base_r, 8 * n);
        chk(hi_bad == 0, "R4 high phase", hi_bad, 0);
        chk(ready_bad == 0, "R5 ready while shifting", ready_bad, 0);
        chk(timeout_err == 0, "R6 no timeout", timeout_err, 0);
    endtask

    task automatic do_check(input int exp, input string req);
        @(negedge clk); check = 1;
        @(negedge clk); check = 0;
        chk(result_valid == 1, req, result_valid, 1);
        chk(int'(result) == exp, req, result, exp);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (5) @(negedge clk);
        chk(cfg_n_o == 1, "R1 reset request high", cfg_n_o, 1);
        chk(s_ready == 0 && busy == 0 && dclk_o == 0, "R5 reset idle", {s_ready, busy, dclk_o}, 0);
        rst_n = 1;
        repeat (10) @(negedge clk);

        // directed single byte, then random loads (R3, R4, R5)
        run_load(1, 0, 0);
        for (int k = 0; k < 6; k++)
            run_load(1 + ($urandom % 5), $urandom % 20, $urandom % 4);

        // R10: empty load
        begin
            int r0, rs0;
            r0 = rises; rs0 = ready_seen;
            run_load(0, 3, 0);
            chk(rises == r0, "R10 no clock on empty load", rises - r0, 0);
            chk(ready_seen == rs0, "R10 ready never raised", ready_seen - rs0, 0);
        end

        // R8, R11: status high, done low then done raised with the request
        repeat (4) @(negedge clk);
        do_check(3, "R8 in progress");
        @(negedge clk); done_i = 1; check = 1;
        @(negedge clk); check = 0;
        chk(int'(result) == 3, "R11 done change not seen by same-cycle check", result, 3);
        repeat (3) @(negedge clk);
        do_check(1, "R8 success");
        done_i = 0;

        // R6: target never answers
        begin
            int r0;
            r0 = rises;
            tgt_fail = 1;
            byte_count = 16'd2;
            timeout_cycles = 20'd30;
            @(negedge clk); start = 1;
            @(negedge clk); start = 0;
            wait_idle();
            chk(timeout_err == 1, "R6 timeout flag", timeout_err, 1);
            chk(rises == r0, "R6 no data clock", rises - r0, 0);
            repeat (5) @(negedge clk);
            chk(timeout_err == 1, "R6 flag sticky", timeout_err, 1);
            do_check(2, "R7 failure result");
            tgt_fail = 0;
        end

        // R9: no-target variant
        begin
            @(negedge clk); nt_start = 1;
            @(negedge clk); nt_start = 0;
            for (int i = 0; i < 3; i++) begin
                nt_valid = 1; nt_data = 8'($urandom);
                while (!nt_ready) @(negedge clk);
                @(negedge clk);
                nt_valid = 0;
            end
            @(negedge clk);
            while (nt_busy) @(negedge clk);
            chk(nt_rises == 24, "R9 load without target", nt_rises, 24);
            chk(nt_err == 0, "R9 no timeout", nt_err, 0);
            @(negedge clk); nt_check = 1;
            @(negedge clk); nt_check = 0;
            chk(nt_rv == 1 && nt_res == 2'b01, "R9 check success", nt_res, 1);
        end

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule